// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital heart of a 32-step programmable potentiometer. Three active-low pins from the board (a select line, an increment strobe and a direction level) are brought into the system clock domain. The block keeps a saturating wiper position from them and drives a one-hot tap select that picks one switch of the resistor ladder. Position 0 is the low end of the ladder and position 31 is the high end.

Releasing the select line ends a session. If the increment strobe is high at that moment, the current position is committed to a modelled nonvolatile register. That store holds a busy flag for a parameterised number of clocks, and the register takes its new value when the busy time ends. If the strobe is low at release, the session ends and the saved value stays as it was, so a trial position can be tried and dropped. After reset the wiper starts from the saved value, whose reset content is the parameter `DEFAULT_POS`.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset, `pos_o` and `nv_pos_o` both equal `DEFAULT_POS` (16 by default) and `busy_o` is low.
- R2: Each falling edge of `inc_n_i` seen while `sel_n_i` is low moves `pos_o` by exactly one step. The change is visible within six clocks of the edge.
- R3: The step direction is taken from `up_dn_i` when the strobe falls: 1 counts up toward position 31, 0 counts down toward position 0.
- R4: The position saturates. An up step at 31 or a down step at 0 leaves `pos_o` unchanged, and it never wraps.
- R5: While `sel_n_i` is high, edges on `inc_n_i` and changes of `up_dn_i` leave `pos_o` unchanged.
- R6: A rising edge of `sel_n_i` while `inc_n_i` is high starts a store. `busy_o` rises, and when it falls `nv_pos_o` holds the position that was current at the release.
- R7: A rising edge of `sel_n_i` while `inc_n_i` is low starts no store. `busy_o` stays low and `nv_pos_o` is unchanged.
- R8: A store holds `busy_o` high for exactly `STORE_CYCLES` consecutive clocks. `nv_pos_o` changes only in the cycle in which `busy_o` falls.
- R9: While `busy_o` is high, strobe edges and select-line activity are ignored. The position does not move and no further store is started, including after the busy time ends.
- R10: `tap_o` has exactly one bit set, and that bit is the one whose index equals `pos_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select pin, asynchronous |
| inc_n_i | input | 1 | Active-low step strobe, asynchronous; its level at select release chooses store or discard |
| up_dn_i | input | 1 | Step direction, 1 = toward high end, 0 = toward low end |
| pos_o | output | POS_W (5) | Current wiper position |
| tap_o | output | 2**POS_W (32) | One-hot tap select |
| busy_o | output | 1 | High while a store is in progress |
| nv_pos_o | output | POS_W (5) | Content of the modelled nonvolatile register |

## Verification
Some rules are checked by the bound checker on every clock. These are: one move per clock of at most one step with no wrap, a frozen position while the synchronized select is high or a store is busy, a one-hot tap that tracks the position, the exact busy length, and a saved value that changes only as busy falls. Other behaviour needs directed pin sequences from the scenarios. These cover the direction sampling, saturation reached through long step runs, and the choice between store and discard made by the strobe level at release. They also show that select and strobe activity during a busy store leaves no delayed store and no late step behind.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;

    // synchronized view of the three control pins, all in pin polarity
    typedef struct packed {
        logic sel;   // select, active low
        logic inc;   // step strobe, active low
        logic dir;   // 1 = up, 0 = down
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sel: 1'b1, inc: 1'b1, dir: 1'b1};

endpackage

// File: rtl/wiper_sync.sv
`timescale 1ns/1ps
module wiper_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] src;
        if (i == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= src;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/wiper_step.sv
`timescale 1ns/1ps
module wiper_step #(
    parameter int POS_W = 5
) (
    input  logic [POS_W-1:0] pos,
    input  logic             step_en,
    input  logic             up,
    output logic [POS_W-1:0] pos_nxt
);

    localparam logic [POS_W-1:0] TOP = '1;
    localparam logic [POS_W-1:0] BOT = '0;

    always_comb begin
        pos_nxt = pos;
        if (step_en) begin
            if (up && pos != TOP)       pos_nxt = pos + 1'b1;
            else if (!up && pos != BOT) pos_nxt = pos - 1'b1;
        end
    end

endmodule

// File: rtl/wiper_decode.sv
`timescale 1ns/1ps
module wiper_decode #(
    parameter int POS_W    = 5,
    parameter int NUM_TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] tap
);

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap[t] = (pos == POS_W'(t));
    end

endmodule

// File: rtl/wiper_nv_store.sv
`timescale 1ns/1ps
module wiper_nv_store #(
    parameter int POS_W        = 5,
    parameter int STORE_CYCLES = 1000,
    parameter int DEFAULT_POS  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [POS_W-1:0] din,
    output logic             busy,
    output logic [POS_W-1:0] nv
);

    localparam int CNT_W = $clog2(STORE_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pend;
        logic [POS_W-1:0] nv;
    } nv_t;

    nv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) st_d.nv = st_q.pend;
        end else if (start) begin
            st_d.cnt  = CNT_W'(STORE_CYCLES);
            st_d.pend = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.pend <= POS_W'(DEFAULT_POS);
            st_q.nv   <= POS_W'(DEFAULT_POS);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);
    assign nv   = st_q.nv;

endmodule

// File: rtl/wiper_ctrl.sv
`timescale 1ns/1ps
module wiper_ctrl #(
    parameter int POS_W        = 5,
    parameter int STORE_CYCLES = 1000,
    parameter int DEFAULT_POS  = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n_i,
    input  logic                    inc_n_i,
    input  logic                    up_dn_i,
    output logic [POS_W-1:0]        pos_o,
    output logic [(1<<POS_W)-1:0]   tap_o,
    output logic                    busy_o,
    output logic [POS_W-1:0]        nv_pos_o
);

    localparam int NUM_TAPS = 1 << POS_W;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        wiper_pkg::ctl_t   prev;
    } core_t;

    core_t           core_d, core_q;
    wiper_pkg::ctl_t ctl_s;
    logic [2:0]      ctl_vec;
    logic            sel_sync;
    logic            inc_fall, sel_rise, step_en, store_go, busy;
    logic [POS_W-1:0] pos_nxt, nv_val;

    wiper_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(wiper_pkg::CTL_IDLE)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n_i, inc_n_i, up_dn_i}),
        .dout (ctl_vec)
    );

    assign ctl_s    = wiper_pkg::ctl_t'(ctl_vec);
    assign sel_sync = ctl_s.sel;

    always_comb begin
        inc_fall = core_q.prev.inc & ~ctl_s.inc;
        sel_rise = ~core_q.prev.sel & sel_sync;
        step_en  = inc_fall & ~sel_sync & ~busy;
        store_go = sel_rise & ctl_s.inc & ~busy;
        core_d      = core_q;
        core_d.pos  = pos_nxt;
        core_d.prev = ctl_s;
    end

    wiper_step #(.POS_W(POS_W)) i_step (
        .pos    (core_q.pos),
        .step_en(step_en),
        .up     (ctl_s.dir),
        .pos_nxt(pos_nxt)
    );

    wiper_nv_store #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .DEFAULT_POS(DEFAULT_POS)) i_nv (
        .clk  (clk),
        .rst_n(rst_n),
        .start(store_go),
        .din  (core_q.pos),
        .busy (busy),
        .nv   (nv_val)
    );

    // the counter starts from the saved register's reset content
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.pos  <= POS_W'(DEFAULT_POS);
            core_q.prev <= wiper_pkg::CTL_IDLE;
        end else begin
            core_q <= core_d;
        end
    end

    wiper_decode #(.POS_W(POS_W), .NUM_TAPS(NUM_TAPS)) i_dec (
        .pos(core_q.pos),
        .tap(tap_o)
    );

    assign pos_o    = core_q.pos;
    assign busy_o   = busy;
    assign nv_pos_o = nv_val;

endmodule

// File: rtl/wiper_ctrl_chk.sv
`timescale 1ns/1ps
module wiper_ctrl_chk #(
    parameter int POS_W        = 5,
    parameter int STORE_CYCLES = 1000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sel_sync,
    input logic [POS_W-1:0]      pos_o,
    input logic [(1<<POS_W)-1:0] tap_o,
    input logic                  busy_o,
    input logic [POS_W-1:0]      nv_pos_o
);

    localparam logic [POS_W-1:0] TOP = '1;

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_o) |-> (({1'b0, pos_o} == {1'b0, $past(pos_o)} + 1'b1) ||
                             ({1'b0, $past(pos_o)} == {1'b0, pos_o} + 1'b1))); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pos_o) == TOP) |-> (pos_o != '0)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pos_o) == '0) |-> (pos_o != TOP)); // R4

    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_sync) |-> $stable(pos_o)); // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> $stable(pos_o)); // R9

    AST_NV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_pos_o) |-> $fell(busy_o)); // R8

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == STORE_CYCLES)); // R8

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_o) == 1) && tap_o[pos_o]); // R10

endmodule

bind wiper_ctrl wiper_ctrl_chk #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_sync(sel_sync),
    .pos_o   (pos_o),
    .tap_o   (tap_o),
    .busy_o  (busy_o),
    .nv_pos_o(nv_pos_o)
);

// File: tb/test_wiper_ctrl.sv
`timescale 1ns/1ps
module test_wiper_ctrl;

    localparam int POS_W = 5;
    localparam int NT    = 1 << POS_W;
    localparam int SC    = 40;
    localparam int DEF   = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, inc_n = 1'b1, up_dn = 1'b1;
    logic [POS_W-1:0] pos_o, nv_pos_o;
    logic [NT-1:0]    tap_o;
    logic             busy_o;

    always #5 clk = ~clk;

    wiper_ctrl #(.POS_W(POS_W), .STORE_CYCLES(SC), .DEFAULT_POS(DEF)) i_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .inc_n_i(inc_n), .up_dn_i(up_dn),
        .pos_o(pos_o), .tap_o(tap_o), .busy_o(busy_o), .nv_pos_o(nv_pos_o)
    );

    typedef struct {
        string req;
        int    pos;
        int    nv;
        int    busy;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   model_pos = DEF, model_nv = DEF;
    bit   done = 0;

    function automatic void check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, "pos", int'(pos_o), e.pos);
                check(e.req, "nv", int'(nv_pos_o), e.nv);
                check(e.req, "busy", int'(busy_o), e.busy);
                check("R10", "tap", int'(tap_o == (NT'(1) << pos_o)), 1);
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string req, input int busy);
        exp_t e;
        e.req = req; e.pos = model_pos; e.nv = model_nv; e.busy = busy;
        q.push_back(e);
        clks(2);
    endtask

    task automatic pulse_inc();
        inc_n = 1'b0; clks(4);
        inc_n = 1'b1; clks(4);
    endtask

    task automatic step(input bit up);
        up_dn = up; clks(3);
        pulse_inc();
        if (sel_n == 1'b0) begin
            if (up && model_pos < NT-1)      model_pos++;
            else if (!up && model_pos > 0)   model_pos--;
        end
    endtask

    task automatic select_on();
        sel_n = 1'b0; clks(4);
    endtask

    // returns number of busy cycles seen after the release
    task automatic release_sel(input bit inc_lvl, output int seen);
        inc_n = inc_lvl; clks(3);
        sel_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 10 && !busy_o; i++) clks(1);
        while (busy_o && seen < 4*SC) begin
            seen++;
            clks(1);
        end
    endtask

    initial begin
        int busy_seen;
        rst_n = 1'b0; clks(4);
        rst_n = 1'b1; clks(2);
        expect_now("R1", 0);

        // R5: strobe and direction activity while deselected
        step(1'b1); step(1'b0); step(1'b1);
        expect_now("R5", 0);

        // R2 R3: single steps in both directions
        select_on();
        step(1'b1); expect_now("R2", 0);
        step(1'b1); step(1'b1); expect_now("R3", 0);
        step(1'b0); step(1'b0); expect_now("R3", 0);

        // R6 R8: store on release with strobe high
        release_sel(1'b1, busy_seen);
        check("R6", "busy rose", int'(busy_seen > 0), 1);
        check("R8", "busy length", busy_seen, SC);
        model_nv = model_pos;
        clks(2);
        expect_now("R6", 0);

        // R4: saturate at the top
        select_on();
        for (int i = 0; i < 20; i++) step(1'b1);
        check("R4", "model top", model_pos, NT-1);
        expect_now("R4", 0);

        // R7: release with strobe low, no store
        release_sel(1'b0, busy_seen);
        check("R7", "busy stayed low", busy_seen, 0);
        inc_n = 1'b1; clks(4);
        expect_now("R7", 0);

        // R4: saturate at the bottom
        select_on();
        for (int i = 0; i < 40; i++) step(1'b0);
        expect_now("R4", 0);

        // R9: activity during a store is ignored
        inc_n = 1'b1; clks(3);
        sel_n = 1'b1;
        for (int i = 0; i < 10 && !busy_o; i++) clks(1);
        check("R9", "busy rose", int'(busy_o), 1);
        sel_n = 1'b0; clks(4);
        up_dn = 1'b1; clks(2);
        pulse_inc();
        sel_n = 1'b1; clks(3);
        expect_now("R9", 1);
        for (int i = 0; i < 4*SC && busy_o; i++) clks(1);
        model_nv = model_pos;
        clks(3);
        expect_now("R9", 0);
        busy_seen = 0;
        for (int i = 0; i < 12; i++) begin
            if (busy_o) busy_seen++;
            clks(1);
        end
        check("R9", "no late store", busy_seen, 0);

        // R1: second reset restores the default
        rst_n = 1'b0; clks(3);
        rst_n = 1'b1; clks(2);
        model_pos = DEF; model_nv = DEF;
        expect_now("R1", 0);

        clks(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule